// File: doc/BRIEF.md
# Serial Input Interrupt Controller

This block raises interrupts from the input bits that a serial GPIO engine deserializes. The engine delivers one input word per burst, holding one bit for each port and bit index, and marks every new word with a valid pulse. The block compares each new word with the previous one, or tests it against an active level, and turns the result into per-pin sticky pending flags. Software reads which pins are interrupting, writes ones to clear the flags, and sees one combined interrupt line that a master enable gates.

Each pin is addressed by a port number and a bit index. Every register holds one bit per port and exists once per bit index. A pin's two-bit trigger type is split over two trigger registers: the low bit sits in the register numbered by the bit index, and the high bit sits in the register numbered by the bit index plus the number of bit indices. The sample stream uses valid/ready, but the block never applies back-pressure: `in_ready` is always high and a word is taken in every cycle that `in_valid` is high. The register port is a plain write strobe with a combinational read.

Top module: `serin_irq`

## Requirements
- R1: After reset every readable register reads 0, no pin is pending and `irq` is low.
- R2: Trigger type codes are 0 = level, 1 = any edge, 2 = falling edge, 3 = rising edge. For bit index b (NBITS = 4), the type low bit of port p is bit p of address b and the high bit is bit p of address b+4; both read back as written.
- R3: For a level-type pin, polarity register b (address 8+b) bit p selects the active level (0 high, 1 low), and every accepted sample with the pin at its active level sets its pending flag.
- R4: Edge-type pins compare the accepted sample with the previously accepted one; the first sample after reset sets no edge-type pending flag.
- R5: A pending flag stays set until a 1 is written to its bit in acknowledge register b (address 16+b); writing 0 leaves it unchanged.
- R6: Identity register b (address 20+b) reads pending AND enable, with enable register b at address 12+b; a disabled pin still latches pending and shows it once enabled.
- R7: `irq` is high exactly when bit 0 of the configuration register (address 24) is 1 and some identity bit is 1.
- R8: When a new event and an acknowledge hit the same pin in one cycle, the pin stays pending.
- R9: Bit b*NPORTS+p of `in_word` is bit index b of port p; `in_ready` is always 1 and words without `in_valid` change no flag.
- R10: Acknowledge addresses read 0, and writes to identity addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | New deserialized input word present |
| in_ready | output | 1 | Always 1; samples are never held off |
| in_word | input | NBITS*NPORTS | Input word, bit index major |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | NPORTS | Write data, one bit per port |
| reg_rdata | output | NPORTS | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The two functions that can meet in one cycle are a fresh sample that fires a pin and a software acknowledge of that same pin. The bench provokes it by writing all ones to an acknowledge register in the very cycle it presents a word that keeps level pins of that bit index active, then reads identity and expects the pin still pending. Around this, a long sweep over every trigger type and both polarities on all ports, with acknowledges at a rotating bit index after each word, is judged against a bench model computed straight from the encoding rules.

// File: rtl/serin_irq_pkg.sv
package serin_irq_pkg;

  typedef enum logic [1:0] {
    TRG_LEVEL = 2'd0,
    TRG_ANY   = 2'd1,
    TRG_FALL  = 2'd2,
    TRG_RISE  = 2'd3
  } trg_e;

  // Event for one pin on an accepted sample.
  function automatic logic pin_event(trg_e t, logic act_low, logic cur,
                                     logic prv, logic primed);
    logic e;
    case (t)
      TRG_LEVEL: e = cur ^ act_low;
      TRG_ANY:   e = primed & (cur ^ prv);
      TRG_FALL:  e = primed & prv & ~cur;
      default:   e = primed & ~prv & cur;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/serin_irq_detect.sv
module serin_irq_detect
  import serin_irq_pkg::*;
#(
  parameter int NPORTS = 32,
  parameter int NBITS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [NBITS-1:0][NPORTS-1:0]  din,
  input  logic [NBITS-1:0][NPORTS-1:0]  trig_lo,
  input  logic [NBITS-1:0][NPORTS-1:0]  trig_hi,
  input  logic [NBITS-1:0][NPORTS-1:0]  pol,
  output logic [NBITS-1:0][NPORTS-1:0]  evt
);

  logic [NBITS-1:0][NPORTS-1:0] prev_q;
  logic                         primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (in_valid) begin
      prev_q   <= din;
      primed_q <= 1'b1;
    end
  end

  for (genvar gb = 0; gb < NBITS; gb++) begin : g_bit
    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
      assign evt[gb][gp] = in_valid &
        pin_event(trg_e'({trig_hi[gb][gp], trig_lo[gb][gp]}), pol[gb][gp],
                  din[gb][gp], prev_q[gb][gp], primed_q);
    end
  end

  // Pins configured with any edge type.
  logic [NBITS-1:0][NPORTS-1:0] edge_mask;
  assign edge_mask = trig_lo | trig_hi;

  // R4
  first_sample_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed_q) |-> ((evt & edge_mask) == '0));

  // R9
  idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (evt == '0));

endmodule

// File: rtl/serin_irq_regs.sv
module serin_irq_regs #(
  parameter int NPORTS = 32,
  parameter int NBITS  = 4,
  parameter int AW     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [NPORTS-1:0]             wdata,
  output logic [NPORTS-1:0]             rdata,
  input  logic [NBITS-1:0][NPORTS-1:0]  evt,
  output logic [NBITS-1:0][NPORTS-1:0]  trig_lo,
  output logic [NBITS-1:0][NPORTS-1:0]  trig_hi,
  output logic [NBITS-1:0][NPORTS-1:0]  pol,
  output logic                          irq
);

  localparam int TRIG_BASE  = 0;
  localparam int POL_BASE   = 2 * NBITS;
  localparam int ENA_BASE   = 3 * NBITS;
  localparam int ACK_BASE   = 4 * NBITS;
  localparam int IDENT_BASE = 5 * NBITS;
  localparam int CFG_ADDR   = 6 * NBITS;

  logic [NBITS-1:0][NPORTS-1:0] ena_q, pend_q, ack_vec, ident;
  logic                         cfg_en_q;

  always_comb begin
    for (int b = 0; b < NBITS; b++)
      ack_vec[b] = (we && addr == AW'(ACK_BASE + b)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_lo  <= '0;
      trig_hi  <= '0;
      pol      <= '0;
      ena_q    <= '0;
      cfg_en_q <= 1'b0;
    end else if (we) begin
      for (int b = 0; b < NBITS; b++) begin
        if (addr == AW'(TRIG_BASE + b))         trig_lo[b] <= wdata;
        if (addr == AW'(TRIG_BASE + NBITS + b)) trig_hi[b] <= wdata;
        if (addr == AW'(POL_BASE + b))          pol[b]     <= wdata;
        if (addr == AW'(ENA_BASE + b))          ena_q[b]   <= wdata;
      end
      if (addr == AW'(CFG_ADDR)) cfg_en_q <= wdata[0];
    end
  end

  // New events are ORed in after the clear, so they win over an acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack_vec) | evt;
  end

  assign ident = pend_q & ena_q;
  assign irq   = cfg_en_q & (ident != '0);

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBITS; b++) begin
      if (addr == AW'(TRIG_BASE + b))         rdata = trig_lo[b];
      if (addr == AW'(TRIG_BASE + NBITS + b)) rdata = trig_hi[b];
      if (addr == AW'(POL_BASE + b))          rdata = pol[b];
      if (addr == AW'(ENA_BASE + b))          rdata = ena_q[b];
      if (addr == AW'(IDENT_BASE + b))        rdata = ident[b];
    end
    if (addr == AW'(CFG_ADDR)) rdata = {{(NPORTS-1){1'b0}}, cfg_en_q};
  end

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_vec != '0) && (evt == '0)) |=> ((pend_q & $past(ack_vec)) == '0));

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_vec == '0) && (evt == '0)) |=> $stable(pend_q));

  // R7
  irq_needs_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_q & ena_q) != '0));

endmodule

// File: rtl/serin_irq.sv
module serin_irq #(
  parameter int NPORTS = 32,
  parameter int NBITS  = 4,
  localparam int AW    = $clog2(6 * NBITS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NBITS*NPORTS-1:0]   in_word,
  input  logic                      reg_we,
  input  logic [AW-1:0]             reg_addr,
  input  logic [NPORTS-1:0]         reg_wdata,
  output logic [NPORTS-1:0]         reg_rdata,
  output logic                      irq
);

  logic [NBITS-1:0][NPORTS-1:0] din, evt, trig_lo, trig_hi, pol;

  assign din      = in_word;
  assign in_ready = 1'b1;

  serin_irq_detect #(.NPORTS(NPORTS), .NBITS(NBITS)) u_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(din),
    .trig_lo(trig_lo), .trig_hi(trig_hi), .pol(pol), .evt(evt)
  );

  serin_irq_regs #(.NPORTS(NPORTS), .NBITS(NBITS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .evt(evt),
    .trig_lo(trig_lo), .trig_hi(trig_hi), .pol(pol), .irq(irq)
  );

  // R9
  always_comb begin
    ready_high_chk: assert (in_ready == 1'b1);
  end

endmodule

// File: tb/serin_irq_bench.sv
`timescale 1ns/1ps
module serin_irq_bench;

  localparam int NP = 32;
  localparam int NB = 4;
  localparam int AW = $clog2(6 * NB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NB*NP-1:0] in_word = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [NP-1:0] reg_wdata = '0;
  logic [NP-1:0] reg_rdata;
  logic irq;

  always #4 clk = ~clk;

  serin_irq u_serin_irq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [NB-1:0][NP-1:0] m_prev, m_pend, m_ena, m_lo, m_hi, m_pol;
  bit m_primed;
  bit m_cfg;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic wr(input int a, input logic [NP-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [NP-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  // Model update from the requirement rules (R3, R4, R5, R8).
  task automatic model_sample(input logic [NB-1:0][NP-1:0] w, input int ackb,
                              input logic [NP-1:0] ackm);
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < NP; p++) begin
        logic e;
        case ({m_hi[b][p], m_lo[b][p]})
          2'd0: e = w[b][p] ^ m_pol[b][p];
          2'd1: e = m_primed & (w[b][p] ^ m_prev[b][p]);
          2'd2: e = m_primed & m_prev[b][p] & ~w[b][p];
          default: e = m_primed & ~m_prev[b][p] & w[b][p];
        endcase
        if (b == ackb && ackm[p]) m_pend[b][p] = 1'b0;
        if (e) m_pend[b][p] = 1'b1;
      end
    end
    m_prev = w;
    m_primed = 1'b1;
  endtask

  // Present one word, optionally with an acknowledge in the same cycle.
  task automatic sample(input logic [NB*NP-1:0] w, input int ackb,
                        input logic [NP-1:0] ackm);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    if (ackb >= 0) begin
      reg_we = 1'b1; reg_addr = AW'(4 * NB + ackb); reg_wdata = ackm;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; reg_we = 1'b0;
    model_sample(w, ackb, ackm);
  endtask

  task automatic check_ident(input string tag);
    logic [NP-1:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(5 * NB + b, d);
      chk(d == (m_pend[b] & m_ena[b]), tag, d, m_pend[b] & m_ena[b]);
    end
  endtask

  task automatic check_irq(input string tag);
    logic exp;
    exp = m_cfg && ((m_pend & m_ena) != '0);
    @(negedge clk); #1;
    chk(irq == exp, tag, {31'd0, irq}, {31'd0, exp});
  endtask

  function automatic logic [NB*NP-1:0] rand_word(input logic [31:0] s);
    logic [NB*NP-1:0] w;
    logic [31:0] x = s;
    for (int b = 0; b < NB; b++) begin
      x = next_rand(x);
      w[b*NP +: NP] = x;
    end
    return w;
  endfunction

  initial begin
    #(200000 * 8);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] d;
    m_prev = '0; m_pend = '0; m_ena = '0; m_lo = '0; m_hi = '0; m_pol = '0;
    m_primed = 1'b0; m_cfg = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state of every register and the interrupt line
    for (int a = 0; a <= 6 * NB; a++) begin
      rd(a, d);
      chk(d == '0, "R1 reset register", d, 0);
    end
    @(negedge clk); #1;
    chk(irq == 1'b0, "R1 reset irq", {31'd0, irq}, 0);
    chk(in_ready == 1'b1, "R9 ready", {31'd0, in_ready}, 1);

    // R2: every type and both polarities spread over ports and bit indices
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < NP; p++) begin
        int t = (p + b) % 4;
        m_lo[b][p] = t[0];
        m_hi[b][p] = t[1];
        m_pol[b][p] = ((p >> 2) & 1) ^ (b & 1);
      end
      wr(b, m_lo[b]);
      wr(b + NB, m_hi[b]);
      wr(2 * NB + b, m_pol[b]);
    end
    for (int b = 0; b < NB; b++) begin
      rd(b, d);      chk(d == m_lo[b], "R2 type low bit", d, m_lo[b]);
      rd(b + NB, d); chk(d == m_hi[b], "R2 type high bit", d, m_hi[b]);
      rd(2 * NB + b, d); chk(d == m_pol[b], "R3 polarity", d, m_pol[b]);
    end
    // Bit index 0 left disabled to test R6 latching.
    for (int b = 1; b < NB; b++) begin
      m_ena[b] = '1;
      wr(3 * NB + b, '1);
    end

    // R4: first sample, all ones, only level pins may fire
    sample('1, -1, '0);
    check_ident("R4 first sample");
    check_irq("R7 master off");

    m_cfg = 1'b1;
    wr(6 * NB, 32'h1);
    check_irq("R7 master on");

    // R3 R4 R5: sweep of words with a rotating acknowledge
    for (int i = 0; i < 60; i++) begin
      rng = next_rand(rng);
      sample(rand_word(rng), (i % 2 == 0) ? -1 : (i % NB), next_rand(rng ^ 32'hA5A5));
      check_ident("R3 R4 R5 sweep");
      check_irq("R7 sweep");
    end

    // R5: writing zero to acknowledge changes nothing
    wr(4 * NB + 1, '0);
    check_ident("R5 zero ack");

    // R6: bit index 0 latched while disabled, now visible
    m_ena[0] = '1;
    wr(3 * NB, '1);
    rd(5 * NB, d);
    chk(d == m_pend[0], "R6 latched while disabled", d, m_pend[0]);

    // R10: identity write ignored, acknowledge reads zero
    wr(5 * NB + 1, '1);
    check_ident("R10 ident write");
    rd(4 * NB + 2, d);
    chk(d == '0, "R10 ack reads zero", d, 0);

    // R8: acknowledge all of bit index 3 in the same cycle as a word
    sample('1, 3, '1);
    rd(5 * NB + 3, d);
    chk(d == (m_pend[3] & m_ena[3]), "R8 event wins", d, m_pend[3] & m_ena[3]);
    chk(m_pend[3] != '0, "R8 pins remain", m_pend[3], 1);

    // R9: word changes without valid touch nothing
    @(negedge clk); in_word = '0;
    repeat (3) @(posedge clk);
    check_ident("R9 no valid");

    // R5 R7: clear everything, line drops
    for (int b = 0; b < NB; b++) begin
      wr(4 * NB + b, '1);
      m_pend[b] = '0;
    end
    check_ident("R5 all cleared");
    check_irq("R7 cleared");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule